// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between a CAN protocol engine and the line driver, on the transmit data line. It works apart from the protocol logic and looks only at whether the line is being driven dominant. Dominant is logic 0 and recessive is logic 1. It counts how many clock cycles in a row the transmit bit has been sampled dominant. If one unbroken dominant stretch goes past a fixed limit, the guard latches a fault. While the fault is latched, the guard holds the transmit output recessive, so a stuck protocol engine cannot clamp the bus.

The limit is a count of clock cycles. It is derived from two parameters: the clock frequency and a timeout in microseconds. The defaults, 100 MHz and 2000 us, give 200,000 cycles, which is about 2 ms. A latched fault stays latched until the system pulses a clear input or resets the block. Clearing the fault does not clear the run counter. If the line is still stuck dominant when the fault is cleared, the guard trips again on the next dominant sample.

Top module: `dtg_dominant_guard`

## Requirements
- R1: While reset is high, and at the first edge after reset falls, `fault` is 0 and `tx_out` equals `tx_in`.
- R2: While no fault is latched, `tx_out` follows `tx_in` combinationally, for both the dominant (0) and recessive (1) values.
- R3: A single cycle with `tx_in` = 1 sets the run count back to zero. A dominant stretch broken by one recessive sample is timed again from its start.
- R4: With LIMIT = clock Hz / 1e6 * timeout us, a stretch of exactly LIMIT dominant samples does not trip. `fault` rises just after the edge that samples dominant for the (LIMIT+1)th cycle in a row.
- R5: While `fault` is 1, `tx_out` is 1, whatever the value of `tx_in`.
- R6: A latched fault stays latched through recessive input. It is released only by `fault_clr` or reset.
- R7: `fault` is 0 just after the edge that samples `fault_clr` = 1. If `tx_in` stays 0, the next dominant sample trips the guard again, because the run count is not cleared.
- R8: When `fault_clr` and a trip condition are sampled on the same edge, the clear wins and `fault` is 0 after that edge.
- R9: The run count saturates at LIMIT and never wraps. After a dominant stretch many times longer than LIMIT, a clear followed by one more dominant sample still trips at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_in | input | 1 | Transmit bit from the protocol engine (0 = dominant) |
| fault_clr | input | 1 | Releases a latched fault at the edge that samples it high |
| tx_out | output | 1 | Gated transmit bit toward the line driver |
| fault | output | 1 | Latched dominant-timeout fault |

## Verification
The hardest case to reach is R9. Saturation of the run count shows at the ports only when a fault is cleared during a dominant stretch far longer than the limit. The bench reaches this with a small limit of 5 cycles and a 3-bit counter. It holds `tx_in` at 0 for many times the counter's range, pulses `fault_clr`, and requires an immediate retrip. A wrapping counter would be partway through a new count and would fail that check. A sweep over every stretch length from 1 to LIMIT+3 pins down the trip edge for R4.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    localparam logic LINE_DOMINANT  = 1'b0;
    localparam logic LINE_RECESSIVE = 1'b1;

    typedef enum logic {
        GUARD_ARMED   = 1'b0,
        GUARD_TRIPPED = 1'b1
    } guard_state_e;

    typedef struct packed {
        logic dominant;
        logic clear;
    } guard_in_t;

    function automatic int unsigned limit_cycles(input int unsigned clk_hz,
                                                 input int unsigned timeout_us);
        return (clk_hz / 1_000_000) * timeout_us;
    endfunction

    function automatic int unsigned count_width(input int unsigned limit);
        int unsigned w;
        w = $clog2(limit + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/dtg_run_counter.sv
module dtg_run_counter #(
    parameter int unsigned LIMIT = 200_000,
    parameter int unsigned CW    = dtg_pkg::count_width(LIMIT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dominant,
    output logic [CW-1:0] count,
    output logic          at_limit
);
    localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (!dominant) begin
            count <= '0;
        end else if (count != LIMIT_V) begin
            count <= count + 1'b1;
        end
    end

    assign at_limit = (count == LIMIT_V);

    assert_count_saturates_R9: assert property (@(posedge clk) disable iff (rst)
        count <= LIMIT_V);

    assert_recessive_restarts_R3: assert property (@(posedge clk) disable iff (rst)
        !dominant |=> count == '0);

endmodule

// File: rtl/dtg_trip_latch.sv
module dtg_trip_latch
    import dtg_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  guard_in_t    req,
    input  logic         at_limit,
    output guard_state_e state,
    output logic         fault
);
    guard_state_e state_nx;

    always_comb begin
        state_nx = state;
        if (req.clear) begin
            state_nx = GUARD_ARMED;
        end else if (req.dominant && at_limit) begin
            state_nx = GUARD_TRIPPED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= GUARD_ARMED;
        else     state <= state_nx;
    end

    assign fault = (state == GUARD_TRIPPED);

    assert_hold_until_clear_R6: assert property (@(posedge clk) disable iff (rst)
        fault && !req.clear |=> fault);

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
        req.clear |=> !fault);

    assert_trip_only_past_limit_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> $past(at_limit && req.dominant));

endmodule

// File: rtl/dtg_dominant_guard.sv
module dtg_dominant_guard
    import dtg_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 100_000_000,
    parameter int unsigned TIMEOUT_US = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_in,
    input  logic fault_clr,
    output logic tx_out,
    output logic fault
);
    localparam int unsigned LIMIT = limit_cycles(CLK_HZ, TIMEOUT_US);
    localparam int unsigned CW    = count_width(LIMIT);

    guard_in_t     req;
    logic [CW-1:0] run_count;
    logic          at_limit;
    guard_state_e  state;

    assign req.dominant = (tx_in == LINE_DOMINANT);
    assign req.clear    = fault_clr;

    dtg_run_counter #(.LIMIT(LIMIT), .CW(CW)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .dominant (req.dominant),
        .count    (run_count),
        .at_limit (at_limit)
    );

    dtg_trip_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .at_limit (at_limit),
        .state    (state),
        .fault    (fault)
    );

    assign tx_out = fault ? LINE_RECESSIVE : tx_in;

    assert_outputs_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> !fault);

    assert_fault_blocks_dominant_R5: assert property (@(posedge clk) disable iff (rst)
        (state == GUARD_TRIPPED) |-> tx_out == LINE_RECESSIVE);

endmodule

// File: tb/dtg_dominant_guard_tb.sv
module dtg_dominant_guard_tb;
    localparam int LIMIT = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_in = 1'b1;
    logic fault_clr = 1'b0;
    logic tx_out, fault;
    int   n_tests = 0;
    int   n_fail = 0;
    bit   done = 0;

    always #5 clk = ~clk;

    dtg_dominant_guard #(.CLK_HZ(1_000_000), .TIMEOUT_US(LIMIT)) u_dut (
        .clk(clk), .rst(rst), .tx_in(tx_in), .fault_clr(fault_clr),
        .tx_out(tx_out), .fault(fault)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic tx, input logic clr);
        @(negedge clk);
        tx_in = tx;
        fault_clr = clr;
        @(posedge clk);
        #1;
    endtask

    task automatic check_out(input string req);
        check(req, tx_out, fault ? 1'b1 : tx_in);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: state during reset and at the first edge after it
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b0);
        check("R1 fault in reset", fault, 1'b0);
        check("R1 tx_out in reset", tx_out, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        tx_in = 1'b1;
        @(posedge clk);
        #1;
        check("R1 fault after reset", fault, 1'b0);
        check("R1 tx_out after reset", tx_out, 1'b1);

        // R2/R4/R5/R6: every stretch length from 1 to LIMIT+3
        for (int n = 1; n <= LIMIT + 3; n++) begin
            cyc(1'b1, 1'b1);
            for (int k = 1; k <= n; k++) begin
                cyc(1'b0, 1'b0);
                check("R4 fault vs stretch", fault, (k > LIMIT));
                check((k > LIMIT) ? "R5 forced recessive" : "R2 pass dominant",
                      tx_out, (k > LIMIT) ? 1'b1 : 1'b0);
            end
            cyc(1'b1, 1'b0);
            check("R6 hold through recessive", fault, (n > LIMIT));
            check_out("R2 pass recessive");
        end

        // R3: one recessive sample restarts the timing
        cyc(1'b1, 1'b1);
        for (int k = 0; k < LIMIT; k++) cyc(1'b0, 1'b0);
        cyc(1'b1, 1'b0);
        for (int k = 1; k <= LIMIT; k++) begin
            cyc(1'b0, 1'b0);
            check("R3 restart after recessive", fault, 1'b0);
        end
        cyc(1'b0, 1'b0);
        check("R3 trip after fresh LIMIT+1", fault, 1'b1);

        // R7: clear during a continuing dominant, then retrip
        cyc(1'b0, 1'b1);
        check("R7 clear drops fault", fault, 1'b0);
        check("R7 tx_out passes after clear", tx_out, 1'b0);
        cyc(1'b0, 1'b0);
        check("R7 retrip on next dominant", fault, 1'b1);
        cyc(1'b1, 1'b1);
        cyc(1'b1, 1'b0);
        check("R7 stays clear when recessive", fault, 1'b0);

        // R8: clear sampled on the same edge as the trip condition
        for (int k = 0; k < LIMIT; k++) cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b1);
        check("R8 clear beats trip", fault, 1'b0);
        cyc(1'b0, 1'b0);
        check("R8 trip follows", fault, 1'b1);

        // R9: a very long stretch keeps the count saturated
        for (int k = 0; k < 40; k++) cyc(1'b0, 1'b0);
        check("R9 fault after long stretch", fault, 1'b1);
        cyc(1'b0, 1'b1);
        check("R9 cleared", fault, 1'b0);
        cyc(1'b0, 1'b0);
        check("R9 immediate retrip", fault, 1'b1);
        check("R5 tx_out recessive", tx_out, 1'b1);

        // R1: reset releases a latched fault
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 reset clears fault", fault, 1'b0);
        rst = 1'b0;

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule